// File: doc/BRIEF.md
# Fixed-Point Requantizer

This block converts a fixed-point value into another fixed-point format, usually a narrower one. Each format is given by a total bit count and a count of integer bits. The number of fraction bits is the total minus the integer count, so a negative integer count describes a value whose leading fraction bits are implied sign or zero bits. Parameters fix both formats and the signedness. The block lines up the binary points first. It then handles any fraction bits that drop off the bottom using one of eight quantization codes, and handles a rounded value that does not fit the output using one of five overflow behaviours.

The result comes out of a single register stage. A valid strobe travels alongside the data. An overflow flag reports whether the rounded value fell outside the output range, and it does so under every overflow mode, including the modes that clip the value. A separate parameter sets how many top output bits the two wrap modes force to a fixed pattern when an overflow occurs.

Top module: `fxq_requant`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by one clock. `data_o` and `ovf_o` load on an edge where `valid_i` is high and hold their values otherwise.
- R2: While `rst_ni` is low, `valid_o`, `data_o` and `ovf_o` are all zero.
- R3: The input carries IN_W-IN_I fraction bits and the output carries OUT_W-OUT_I fraction bits, and either integer count may be negative. When the output has more fraction bits, the input is shifted left and no bits are lost.
- R4: Truncation modes: `qmode_i` 0 and 7 take the floor of the aligned value. Code 6 moves toward zero: a negative value with nonzero dropped bits gets +1.
- R5: Rounding modes send a value that is not a tie to the nearest output code. A tie is broken as follows: code 1 rounds up, code 2 rounds toward zero, code 3 rounds down, code 4 rounds away from zero, and code 5 rounds to the even code.
- R6: Rounding happens before the range check. `ovf_o` is 1 exactly when the rounded value lies outside the output range, whatever `omode_i` is.
- R7: `omode_i` 0 (and the unused codes 5 to 7) keeps the low OUT_W bits. When SAT_BITS=N>0 and the value overflows, the top N bits are taken from the maximum code pattern if the value is positive, or from the minimum code pattern if it is negative.
- R8: `omode_i` 1 clips an overflowing value to the maximum or minimum code.
- R9: `omode_i` 2 outputs zero on overflow.
- R10: `omode_i` 3, signed: the result is clamped to [-MAX, MAX], so the most negative code never appears. Unsigned: same as code 1.
- R11: `omode_i` 4, signed, on overflow: with N=0, the low OUT_W bits are taken and inverted if their MSB differs from the sign of the value. With N>0, the top N bits all equal that sign and the rest are the low bits. Unsigned: same as code 0.
- R12: A rounded value that is in range is output unchanged in every overflow mode, except that code 3 maps the most negative code as R10 states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample valid |
| data_i | input | IN_W | Input fixed-point value |
| qmode_i | input | 3 | Quantization mode code |
| omode_i | input | 3 | Overflow mode code |
| valid_o | output | 1 | Result valid |
| data_o | output | OUT_W | Requantized value |
| ovf_o | output | 1 | Rounded value was out of range |

## Verification
Every result appears exactly one clock edge after the edge that captured its input, because alignment, rounding and range handling are all combinational in front of a single register. The bench changes inputs on the falling edge, waits for the next falling edge and then compares `data_o`, `ovf_o` and `valid_o` with values it worked out for that stimulus. This places every sample half a cycle after the register has loaded. For cycles where `valid_i` is low, the bench expects the outputs captured last. Four instances cover a signed narrowing format, the same format with forced top bits, an unsigned format with negative integer counts, and a widening format.

// File: rtl/fxq_pkg.sv
package fxq_pkg;
  typedef enum logic [2:0] {
    Q_FLOOR      = 3'd0,
    Q_HALF_UP    = 3'd1,
    Q_HALF_ZERO  = 3'd2,
    Q_HALF_DOWN  = 3'd3,
    Q_HALF_AWAY  = 3'd4,
    Q_HALF_EVEN  = 3'd5,
    Q_TO_ZERO    = 3'd6,
    Q_FLOOR_ALT  = 3'd7
  } qmode_e;

  typedef enum logic [2:0] {
    O_WRAP     = 3'd0,
    O_SAT      = 3'd1,
    O_SAT_ZERO = 3'd2,
    O_SAT_SYM  = 3'd3,
    O_WRAP_SM  = 3'd4
  } omode_e;
endpackage

// File: rtl/fxq_round.sv
module fxq_round #(
  parameter int IN_W      = 8,
  parameter int SH        = 2,
  parameter int WW        = 12,
  parameter bit IS_SIGNED = 1'b1
) (
  input  logic [IN_W-1:0]      data_i,
  input  logic [2:0]           qmode_i,
  output logic signed [WW-1:0] r_o
);
  import fxq_pkg::*;

  localparam int LSH = (SH < 0) ? -SH : 0;

  logic signed [WW-1:0] x;
  assign x = {{(WW-IN_W){IS_SIGNED && data_i[IN_W-1]}}, data_i};

  generate
    if (SH > 0) begin : g_drop
      localparam logic [SH-1:0] HALF = (SH)'(1) << (SH-1);
      logic signed [WW-1:0] q;
      logic [SH-1:0] rem;
      logic gt, tie, nz, neg, up;

      always_comb begin
        q   = x >>> SH;
        rem = x[SH-1:0];
        gt  = rem > HALF;
        tie = rem == HALF;
        nz  = |rem;
        neg = x[WW-1];
        unique case (qmode_e'(qmode_i))
          Q_HALF_UP:   up = gt | tie;
          Q_HALF_ZERO: up = gt | (tie & neg);
          Q_HALF_DOWN: up = gt;
          Q_HALF_AWAY: up = gt | (tie & ~neg);
          Q_HALF_EVEN: up = gt | (tie & q[0]);
          Q_TO_ZERO:   up = neg & nz;
          default:     up = 1'b0;
        endcase
        r_o = q + {{(WW-1){1'b0}}, up};
      end
    end else begin : g_widen
      // no bits dropped: exact left shift
      assign r_o = x <<< LSH;
    end
  endgenerate
endmodule

// File: rtl/fxq_ovf.sv
module fxq_ovf #(
  parameter int OUT_W     = 5,
  parameter int WW        = 12,
  parameter bit IS_SIGNED = 1'b1,
  parameter int SAT_BITS  = 0
) (
  input  logic signed [WW-1:0] r_i,
  input  logic [2:0]           omode_i,
  output logic [OUT_W-1:0]     data_o,
  output logic                 ovf_o
);
  import fxq_pkg::*;

  localparam logic signed [WW-1:0] ONE   = 1;
  localparam logic signed [WW-1:0] MAX_V = IS_SIGNED ? (ONE <<< (OUT_W-1)) - ONE
                                                     : (ONE <<< OUT_W) - ONE;
  localparam logic signed [WW-1:0] MIN_V = IS_SIGNED ? -(ONE <<< (OUT_W-1)) : '0;
  localparam logic signed [WW-1:0] SYM_V = -MAX_V;
  localparam logic [OUT_W-1:0] P_MAX = MAX_V[OUT_W-1:0];
  localparam logic [OUT_W-1:0] P_MIN = MIN_V[OUT_W-1:0];
  localparam logic [OUT_W-1:0] P_SYM = SYM_V[OUT_W-1:0];
  localparam int NB = (SAT_BITS > OUT_W) ? OUT_W : SAT_BITS;
  localparam logic [OUT_W-1:0] HI_M = ~({OUT_W{1'b1}} >> NB);

  logic hi, lo, neg;
  logic [OUT_W-1:0] w, wrap_v, fill;

  always_comb begin
    hi    = r_i > MAX_V;
    lo    = r_i < MIN_V;
    ovf_o = hi | lo;
    neg   = r_i[WW-1];
    w     = r_i[OUT_W-1:0];
    fill  = neg ? P_MIN : P_MAX;
    wrap_v = (ovf_o && NB > 0) ? ((w & ~HI_M) | (fill & HI_M)) : w;
    unique case (omode_e'(omode_i))
      O_SAT:      data_o = hi ? P_MAX : (lo ? P_MIN : w);
      O_SAT_ZERO: data_o = ovf_o ? '0 : w;
      O_SAT_SYM: begin
        if (IS_SIGNED) data_o = hi ? P_MAX : ((r_i < SYM_V) ? P_SYM : w);
        else           data_o = hi ? P_MAX : (lo ? P_MIN : w);
      end
      O_WRAP_SM: begin
        if (IS_SIGNED && ovf_o) begin
          if (NB == 0) data_o = (w[OUT_W-1] != neg) ? ~w : w;
          else         data_o = (w & ~HI_M) | ({OUT_W{neg}} & HI_M);
        end else begin
          data_o = wrap_v;
        end
      end
      default:    data_o = wrap_v;
    endcase
  end
endmodule

// File: rtl/fxq_requant.sv
module fxq_requant #(
  parameter int IN_W      = 8,
  parameter int IN_I      = 4,
  parameter int OUT_W     = 5,
  parameter int OUT_I     = 3,
  parameter bit IS_SIGNED = 1'b1,
  parameter int SAT_BITS  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  data_i,
  input  logic [2:0]       qmode_i,
  input  logic [2:0]       omode_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o,
  output logic             ovf_o
);
  import fxq_pkg::*;

  localparam int IN_F  = IN_W - IN_I;
  localparam int OUT_F = OUT_W - OUT_I;
  localparam int SH    = IN_F - OUT_F;
  localparam int LSH   = (SH < 0) ? -SH : 0;
  localparam int W_A   = (IN_W + LSH > OUT_W) ? IN_W + LSH : OUT_W;
  localparam int WW    = ((W_A > SH) ? W_A : SH) + 2;
  localparam logic [OUT_W-1:0] P_MIN = IS_SIGNED ? {1'b1, {(OUT_W-1){1'b0}}} : '0;
  localparam logic [OUT_W-1:0] P_MAX = IS_SIGNED ? {1'b0, {(OUT_W-1){1'b1}}} : '1;

  logic signed [WW-1:0] r_c;
  logic [OUT_W-1:0]     d_c;
  logic                 ovf_c;

  fxq_round #(.IN_W(IN_W), .SH(SH), .WW(WW), .IS_SIGNED(IS_SIGNED)) u_round (
    .data_i (data_i),
    .qmode_i(qmode_i),
    .r_o    (r_c)
  );

  fxq_ovf #(.OUT_W(OUT_W), .WW(WW), .IS_SIGNED(IS_SIGNED), .SAT_BITS(SAT_BITS)) u_ovf (
    .r_i    (r_c),
    .omode_i(omode_i),
    .data_o (d_c),
    .ovf_o  (ovf_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o <= d_c;
        ovf_o  <= ovf_c;
      end
    end
  end

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(data_o) && $stable(ovf_o)));
  p_sat_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && omode_i == O_SAT_ZERO) |=> (!ovf_o || data_o == '0));
  p_sat_clip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && omode_i == O_SAT) |=> (!ovf_o || data_o == P_MAX || data_o == P_MIN));
  p_pass_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ovf_c && omode_i != O_SAT_SYM) |=> data_o == $past(r_c[OUT_W-1:0]));

  generate
    if (IS_SIGNED) begin : g_sym_chk
      p_no_min_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && omode_i == O_SAT_SYM) |=> data_o != P_MIN);
    end
  endgenerate
endmodule

// File: tb/sim_fxq_requant.sv
module sim_fxq_requant;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [7:0] din = '0;
  logic [2:0] qm = '0, om = '0;

  logic v0, v1, v2, v3, f0, f1, f2, f3;
  logic [4:0] d0, d1;
  logic [2:0] d2;
  logic [5:0] d3;

  int n_chk = 0, n_bad = 0;
  int e_d[4];
  bit e_f[4];

  always #5ns clk = ~clk;

  fxq_requant #(.IN_W(8), .IN_I(4), .OUT_W(5), .OUT_I(3), .IS_SIGNED(1'b1), .SAT_BITS(0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .data_i(din), .qmode_i(qm), .omode_i(om),
    .valid_o(v0), .data_o(d0), .ovf_o(f0));
  fxq_requant #(.IN_W(8), .IN_I(4), .OUT_W(5), .OUT_I(3), .IS_SIGNED(1'b1), .SAT_BITS(2)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .data_i(din), .qmode_i(qm), .omode_i(om),
    .valid_o(v1), .data_o(d1), .ovf_o(f1));
  fxq_requant #(.IN_W(8), .IN_I(-1), .OUT_W(3), .OUT_I(-2), .IS_SIGNED(1'b0), .SAT_BITS(0)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .data_i(din), .qmode_i(qm), .omode_i(om),
    .valid_o(v2), .data_o(d2), .ovf_o(f2));
  fxq_requant #(.IN_W(4), .IN_I(2), .OUT_W(6), .OUT_I(2), .IS_SIGNED(1'b1), .SAT_BITS(0)) u3 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .data_i(din[3:0]), .qmode_i(qm), .omode_i(om),
    .valid_o(v3), .data_o(d3), .ovf_o(f3));

  function automatic string q_tag(int m);
    if (m == 0 || m == 6 || m == 7) return "R4";
    return "R5";
  endfunction

  function automatic string o_tag(int m);
    case (m)
      1: return "R8";
      2: return "R9";
      3: return "R10";
      4: return "R11";
      default: return "R7";
    endcase
  endfunction

  // independent integer model of the requantizer
  function automatic void model(input int raw, input int iw, input int sh, input int ow,
                                input bit sgn, input int n, input int qmd, input int omd,
                                output int d, output bit ov);
    longint v, q, rem, sz, r, mx, mn, w, full, hm, res;
    bit neg, tie, gt, up, rneg;
    int nb;
    v = raw & ((longint'(1) << iw) - 1);
    if (sgn && v >= (longint'(1) << (iw-1))) v = v - (longint'(1) << iw);
    if (sh > 0) begin
      sz = longint'(1) << sh;
      q = v >>> sh;
      rem = v - q * sz;
    end else begin
      sz = 1;
      q = v * (longint'(1) << (-sh));
      rem = 0;
    end
    neg = v < 0;
    tie = (sh > 0) && (2 * rem == sz);
    gt  = 2 * rem > sz;
    case (qmd)
      1: up = gt | tie;
      2: up = gt | (tie & neg);
      3: up = gt;
      4: up = gt | (tie & !neg);
      5: up = gt | (tie & q[0]);
      6: up = neg && rem != 0;
      default: up = 1'b0;
    endcase
    r = q + longint'(up);
    full = (longint'(1) << ow) - 1;
    mx = sgn ? (longint'(1) << (ow-1)) - 1 : full;
    mn = sgn ? -(longint'(1) << (ow-1)) : 0;
    ov = (r > mx) || (r < mn);
    rneg = r < 0;
    w = r & full;
    nb = (n > ow) ? ow : n;
    hm = ((longint'(1) << nb) - 1) << (ow - nb);
    if (omd == 1) res = (r > mx) ? mx : ((r < mn) ? mn : r);
    else if (omd == 2) res = ov ? 0 : r;
    else if (omd == 3 && sgn) res = (r > mx) ? mx : ((r < -mx) ? -mx : r);
    else if (omd == 3) res = (r > mx) ? mx : ((r < mn) ? mn : r);
    else if (omd == 4 && sgn && ov) begin
      if (nb == 0) res = (((w >> (ow-1)) & 1) != longint'(rneg)) ? (~w & full) : w;
      else res = (w & ~hm) | ((rneg ? full : 0) & hm);
    end else begin
      res = (ov && nb > 0) ? ((w & ~hm) | ((rneg ? mn : mx) & full & hm)) : w;
    end
    d = int'(res & full);
  endfunction

  task automatic chk(input string tag, input string who, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, who, got, exp);
    end
  endtask

  task automatic apply(input bit v, input int raw, input int qv, input int ov);
    string dt;
    vld = v; din = raw[7:0]; qm = qv[2:0]; om = ov[2:0];
    if (v) begin
      model(raw, 8, 2, 5, 1'b1, 0, qv, ov, e_d[0], e_f[0]);
      model(raw, 8, 2, 5, 1'b1, 2, qv, ov, e_d[1], e_f[1]);
      model(raw, 8, 4, 3, 1'b0, 0, qv, ov, e_d[2], e_f[2]);
      model(raw & 15, 4, -2, 6, 1'b1, 0, qv, ov, e_d[3], e_f[3]);
    end
    @(negedge clk);
    chk("R1", "u0 valid", int'(v0), int'(v));
    chk("R1", "u2 valid", int'(v2), int'(v));
    dt = !v ? "R1" : (e_f[0] ? o_tag(ov) : q_tag(qv));
    chk(dt, "u0 data", int'(d0), e_d[0]);
    chk(v ? "R6" : "R1", "u0 ovf", int'(f0), int'(e_f[0]));
    dt = !v ? "R1" : (e_f[1] ? o_tag(ov) : "R12");
    chk(dt, "u1 data", int'(d1), e_d[1]);
    chk(v ? "R6" : "R1", "u1 ovf", int'(f1), int'(e_f[1]));
    dt = !v ? "R1" : (e_f[2] ? o_tag(ov) : "R3");
    chk(dt, "u2 data", int'(d2), e_d[2]);
    chk(v ? "R6" : "R1", "u2 ovf", int'(f2), int'(e_f[2]));
    chk(v ? "R3" : "R1", "u3 data", int'(d3), e_d[3]);
    chk(v ? "R3" : "R1", "u3 ovf", int'(f3), int'(e_f[3]));
  endtask

  initial begin
    #2ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) begin e_d[i] = 0; e_f[i] = 1'b0; end
    repeat (3) @(negedge clk);
    // R2: outputs cleared while in reset
    chk("R2", "u0 valid rst", int'(v0), 0);
    chk("R2", "u0 data rst", int'(d0), 0);
    chk("R2", "u0 ovf rst", int'(f0), 0);
    chk("R2", "u2 data rst", int'(d2), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed ties: 0x06 = 1.5 LSB, 0xFA = -1.5 LSB, 0x0A = 2.5 LSB, most-negative input
    for (int qv = 0; qv < 8; qv++) begin
      apply(1'b1, 8'h06, qv, 0);
      apply(1'b1, 8'hFA, qv, 0);
      apply(1'b1, 8'h0A, qv, 0);
      apply(1'b1, 8'h80, qv, 3);
      apply(1'b1, 8'h7E, qv, 1);
    end
    // R1: held outputs while idle, with changing inputs
    apply(1'b0, 8'h33, 4, 2);
    apply(1'b0, 8'hC1, 1, 4);
    // exhaustive sweep over every mode pair
    for (int ov = 0; ov < 8; ov++)
      for (int qv = 0; qv < 8; qv++)
        for (int raw = 0; raw < 256; raw++)
          apply(1'b1, raw, qv, ov);
    // random mix with idle cycles
    for (int k = 0; k < 3000; k++)
      apply(($urandom % 4) != 0, $urandom % 256, $urandom % 8, $urandom % 8);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule